// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a register-mapped master for the two-wire PHY management bus (clause-22 frames). Software first sets a clock divisor and an enable bit. It then loads a 16-bit value into a staging register if it wants a write, and writes a command word that holds the PHY address, the register address, the operation and a start bit. The block then sends one complete frame on the management clock and data lines and captures read data from the PHY.

Each host-clock divisor setting `div` gives a management clock that toggles every `div + 1` host clocks, so fMDC = fclk / (2·(div + 1)). Software keeps fMDC at or below 2.5 MHz by choosing div = ceil(fclk / 5 MHz) − 1. A single ready flag tells software when a new command is accepted. The last captured PHY value stays in the read-data register until the next read frame finishes.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0, the command register (offset 0x4) reads 0x00000080 (ready set, all fields zero), `mdc` is low and `mdio_oe` is low.
- R2: While enabled, `mdc` stays high for exactly `div + 1` host clocks and low for `div + 1` host clocks, where `div` is control bits [5:0].
- R3: While the enable bit (control bit 6) is clear, `mdc` stays low, `mdio_oe` stays low, and a start request is ignored, so ready stays 1.
- R4: A write frame is 64 bits, sent MSB first and sampled by the PHY on rising `mdc`: 32 ones, start `01`, opcode `01`, the 5-bit PHY address, the 5-bit register address, turnaround `10`, then the 16 bits of the write-data register (offset 0x8). `mdio_oe` is high for all 64 bits.
- R5: The command word uses these fields: PHY address [28:24], register address [20:16], operation [15:14] (`10` = read, any other value = write), start bit 11. Ready (bit 7, read-only) drops to 0 on the clock edge that accepts the start.
- R6: A command write while ready is 0 is ignored. It starts no frame and leaves the stored address and operation fields unchanged.
- R7: `mdio_o` changes only at falling edges of `mdc`, so it is stable across every rising edge.
- R8: A read frame sends the same header with opcode `10`. `mdio_oe` goes low from bit 46 (the first turnaround bit) to the end of the frame, and `mdio_i` is sampled on the rising `mdc` edges of bits 48 to 63.
- R9: After a read, offset 0xC returns the 16 sampled bits (first sampled bit in bit 15) in bits [15:0], and bits [31:16] read as 0.
- R10: Ready returns to 1 on the second falling `mdc` edge after the rising edge of the last data bit, that is 3·(div+1) host clocks after that rising edge.
- R11: The control register reads back as written: divisor in bits [5:0] and enable in bit 6. Register read data appears on `bus_rdata` one clock after `bus_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data seen on the pin |

## Verification
A wrong bit counter or a corrupted shift register shows up directly in the frame. The header bits seen at the rising `mdc` edges differ from the command, or the output enable is released at the wrong bit, and both are seen within that same frame. A stuck state in the sequencer shows at the ports as ready either never returning, which the poll detects, or returning a clock early or late against the fixed 3·(div+1) window after the last data bit. A divider miscount shows as a wrong half-period length within two `mdc` periods of a change in the divisor.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int PHY_W      = 5;
  localparam int REGA_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_LEN    = 32;
  localparam int FRAME_LEN  = PRE_LEN + 2 + 2 + PHY_W + REGA_W + 2 + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_LEN);
  localparam int TA_IDX     = PRE_LEN + 4 + PHY_W + REGA_W;
  localparam int DAT_IDX    = TA_IDX + 2;

  localparam logic [1:0] OPC_RD  = 2'b10;
  localparam logic [1:0] OPC_WR  = 2'b01;
  localparam logic [1:0] SOF     = 2'b01;
  localparam logic [1:0] TA_DRV  = 2'b10;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_WDAT = 2'd2;
  localparam logic [1:0] SEL_RDAT = 2'd3;

  localparam int CMD_PHY_LSB  = 24;
  localparam int CMD_REG_LSB  = 16;
  localparam int CMD_OP_LSB   = 14;
  localparam int CMD_GO_BIT   = 11;
  localparam int CMD_RDY_BIT  = 7;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ALIGN,
    SQ_SHIFT,
    SQ_TAIL
  } seq_t;
endpackage

// File: rtl/mdm_clkdiv.sv
module mdm_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap      = en && (cnt >= div);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);
endmodule

// File: rtl/mdm_engine.sv
module mdm_engine
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              start,
  input  logic              is_read,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REGA_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  seq_t                 st;
  logic [FRAME_LEN-1:0] frame;
  logic [CNT_W-1:0]     bitcnt;
  logic                 rd_mode;
  logic [DATA_W-1:0]    rd_sh;
  logic [CNT_W-1:0]     nxt_cnt;

  assign nxt_cnt = bitcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      frame    <= '0;
      bitcnt   <= '0;
      rd_mode  <= 1'b0;
      rd_sh    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      ready    <= 1'b1;
    end else begin
      rd_valid <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (start) begin
            frame   <= {{PRE_LEN{1'b1}}, SOF, (is_read ? OPC_RD : OPC_WR),
                        phy, regad, TA_DRV, wdata};
            rd_mode <= is_read;
            ready   <= 1'b0;
            st      <= SQ_ALIGN;
          end
        end
        SQ_ALIGN: begin
          if (fall_tick) begin
            mdio_o  <= frame[FRAME_LEN-1];
            mdio_oe <= 1'b1;
            bitcnt  <= '0;
            st      <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: begin
          if (rise_tick && rd_mode && (bitcnt >= CNT_W'(DAT_IDX))) begin
            rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
            if (bitcnt == CNT_W'(FRAME_LEN-1)) begin
              rd_data  <= {rd_sh[DATA_W-2:0], mdio_i};
              rd_valid <= 1'b1;
            end
          end
          if (fall_tick) begin
            if (bitcnt == CNT_W'(FRAME_LEN-1)) begin
              mdio_o  <= 1'b1;
              mdio_oe <= 1'b0;
              st      <= SQ_TAIL;
            end else begin
              frame   <= {frame[FRAME_LEN-2:0], 1'b0};
              mdio_o  <= frame[FRAME_LEN-2];
              mdio_oe <= !(rd_mode && (nxt_cnt >= CNT_W'(TA_IDX)));
              bitcnt  <= nxt_cnt;
            end
          end
        end
        SQ_TAIL: begin
          if (fall_tick) begin
            ready <= 1'b1;
            st    <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  p_ready_drop_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> !ready);

  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (st != SQ_IDLE) |-> !ready);

  p_mdio_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (mdio_o != $past(mdio_o)) |-> $past(fall_tick));

  p_oe_read_release_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_mode && st == SQ_SHIFT && bitcnt >= CNT_W'(TA_IDX)) |-> !mdio_oe);
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              en,
  output logic [DIV_W-1:0]  div,
  output logic [PHY_W-1:0]  phy,
  output logic [REGA_W-1:0] regad,
  output logic [1:0]        op,
  output logic [DATA_W-1:0] wdata,
  output logic              start
);
  localparam int EN_BIT = DIV_W;

  logic [1:0]        sel;
  logic              cmd_wr;
  logic [DATA_W-1:0] rd_hold;
  logic [BUS_W-1:0]  rmux;

  assign sel    = bus_addr[3:2];
  assign cmd_wr = bus_we && (sel == SEL_CMD);
  assign start  = cmd_wr && bus_wdata[CMD_GO_BIT] && ready && en;

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      div     <= '0;
      phy     <= '0;
      regad   <= '0;
      op      <= '0;
      wdata   <= '0;
      rd_hold <= '0;
    end else begin
      if (bus_we && sel == SEL_CTRL) begin
        div <= bus_wdata[DIV_W-1:0];
        en  <= bus_wdata[EN_BIT];
      end
      if (bus_we && sel == SEL_WDAT)
        wdata <= bus_wdata[DATA_W-1:0];
      if (start) begin
        phy   <= bus_wdata[CMD_PHY_LSB +: PHY_W];
        regad <= bus_wdata[CMD_REG_LSB +: REGA_W];
        op    <= bus_wdata[CMD_OP_LSB +: 2];
      end
      if (rd_valid)
        rd_hold <= rd_data;
    end
  end

  always_comb begin
    rmux = '0;
    unique case (sel)
      SEL_CTRL: begin
        rmux[DIV_W-1:0] = div;
        rmux[EN_BIT]    = en;
      end
      SEL_CMD: begin
        rmux[CMD_PHY_LSB +: PHY_W]  = phy;
        rmux[CMD_REG_LSB +: REGA_W] = regad;
        rmux[CMD_OP_LSB +: 2]       = op;
        rmux[CMD_RDY_BIT]           = ready;
      end
      SEL_WDAT: rmux[DATA_W-1:0] = wdata;
      SEL_RDAT: rmux[DATA_W-1:0] = rd_hold;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rmux;
  end

  p_fields_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !ready) |=> ($stable(phy) && $stable(regad) && $stable(op)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdm_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              en, start, ready, rd_valid, rise_tick, fall_tick;
  logic [DIV_W-1:0]  div;
  logic [PHY_W-1:0]  phy;
  logic [REGA_W-1:0] regad;
  logic [1:0]        op;
  logic [DATA_W-1:0] wdata, rd_data;
  logic              cmd_is_read;

  assign cmd_is_read = (bus_wdata[CMD_OP_LSB +: 2] == OPC_RD);

  mdm_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready(ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .en(en), .div(div),
    .phy(phy), .regad(regad), .op(op), .wdata(wdata), .start(start)
  );

  mdm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(en), .div(div), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdm_engine u_eng (
    .clk(clk), .rst(rst), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .start(start), .is_read(cmd_is_read),
    .phy(bus_wdata[CMD_PHY_LSB +: PHY_W]),
    .regad(bus_wdata[CMD_REG_LSB +: REGA_W]),
    .wdata(wdata), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;
  int frames_seen = 0;
  int frames_issued = 0;
  int cur_h = 1;
  bit done = 0;

  typedef struct {
    logic [63:0] bits;
    bit          rd;
    logic [15:0] rdv;
    int          h;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_ready();
    bus_addr = 4'h4;
    @(negedge clk);
    while (!bus_rdata[7]) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd_word(input logic [1:0] op, input logic [4:0] p,
                                           input logic [4:0] r);
    return (32'(p) << 24) | (32'(r) << 16) | (32'(op) << 14) | 32'h800;
  endfunction

  // Driver: pushes the expected frame, then starts it.
  task automatic issue(input bit rd, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] val, input bit wait_done);
    exp_t e;
    logic [31:0] d;
    e.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, val};
    e.rd = rd; e.rdv = val; e.h = cur_h;
    q.push_back(e);
    frames_issued++;
    if (!rd) bus_write(4'h8, {16'h0, val});
    bus_write(4'h4, cmd_word(rd ? 2'b10 : 2'b01, p, r));
    @(negedge clk);
    check(bus_rdata[7] == 1'b0, "R5 ready low after start", 64'(bus_rdata[7]), 64'd0);
    if (wait_done) begin
      wait_ready();
      if (rd) begin
        bus_read(4'hC, d);
        check(d == {16'h0, val}, "R9 read data register", 64'(d), 64'({16'h0, val}));
      end
    end
  endtask

  // Monitor: acts as the PHY and compares each frame with the scoreboard.
  initial begin
    exp_t e;
    logic [63:0] got;
    bit oe_ok, hold_ok, exp_oe;
    logic v;
    int n;
    forever begin
      @(posedge mdc);
      if (mdio_oe !== 1'b1) continue;
      frames_seen++;
      if (q.size() == 0) begin
        check(1'b0, "R6 unexpected frame", 64'(frames_seen), 64'(frames_issued));
        e.bits = '0; e.rd = 0; e.rdv = '0; e.h = cur_h;
      end else begin
        e = q.pop_front();
      end
      got = '0; oe_ok = 1; hold_ok = 1;
      for (int k = 0; k < 64; k++) begin
        if (k > 0) begin
          @(negedge mdc);
          mdio_i = (e.rd && k >= 48) ? e.rdv[63-k] : 1'b1;
          @(posedge mdc);
        end
        got[63-k] = mdio_o;
        exp_oe = !(e.rd && k >= 46);
        if (mdio_oe !== exp_oe) oe_ok = 0;
        if (k < 63) begin
          v = mdio_o;
          @(negedge clk);
          if (mdio_o !== v) hold_ok = 0;
        end
      end
      mdio_i = 1'b1;
      if (e.rd) begin
        check(got[63:18] == e.bits[63:18], "R8 read header bits",
              64'(got[63:18]), 64'(e.bits[63:18]));
        check(oe_ok, "R8 output enable released from turnaround", 64'(oe_ok), 64'd1);
      end else begin
        check(got == e.bits, "R4 write frame bits", got, e.bits);
        check(oe_ok, "R4 output enable across write frame", 64'(oe_ok), 64'd1);
      end
      check(hold_ok, "R7 mdio_o held after rising mdc", 64'(hold_ok), 64'd1);
      n = 0;
      @(negedge clk);
      while (!bus_rdata[7] && n < 1000) begin n++; @(negedge clk); end
      check(n == 3*e.h + 1, "R10 ready return timing", 64'(n), 64'(3*e.h + 1));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic half_period(input int h);
    int n;
    @(posedge mdc); @(posedge mdc); @(posedge mdc);
    n = 0;
    @(negedge clk);
    while (mdc) begin n++; @(negedge clk); end
    check(n == h, "R2 mdc high time", 64'(n), 64'(h));
    n = 0;
    while (!mdc) begin n++; @(negedge clk); end
    check(n == h, "R2 mdc low time", 64'(n), 64'(h));
  endtask

  initial begin
    logic [31:0] d;
    bit stuck;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check(mdc == 0 && mdio_oe == 0, "R1 pins idle after reset",
          64'({mdc, mdio_oe}), 64'd0);
    bus_read(4'h0, d);
    check(d == 32'h0, "R1 control after reset", 64'(d), 64'h0);
    bus_read(4'h4, d);
    check(d == 32'h80, "R1 command after reset", 64'(d), 64'h80);

    // R3 disabled: mdc idle, start ignored
    bus_write(4'h0, 32'h02);
    bus_write(4'h4, cmd_word(2'b01, 5'h3, 5'h4));
    stuck = 0;
    repeat (60) begin @(negedge clk); if (mdc || mdio_oe) stuck = 1; end
    check(!stuck, "R3 mdc and oe idle while disabled", 64'(stuck), 64'd0);
    bus_read(4'h4, d);
    check(d == 32'h80, "R3 start ignored while disabled", 64'(d), 64'h80);

    // R11 control readback, R2 divider
    bus_write(4'h0, 32'h43);
    bus_read(4'h0, d);
    check(d == 32'h43, "R11 control readback", 64'(d), 64'h43);
    half_period(4);
    bus_write(4'h0, 32'h40);
    half_period(1);
    bus_write(4'h0, 32'h45);
    half_period(6);

    // Frames at div=2
    bus_write(4'h0, 32'h42);
    cur_h = 3;
    issue(0, 5'h13, 5'h0A, 16'hA5C3, 1);
    issue(0, 5'h00, 5'h1F, 16'h0001, 1);
    issue(1, 5'h1F, 5'h00, 16'h8001, 1);
    issue(1, 5'h0A, 5'h15, 16'hFFFF, 1);
    bus_read(4'h4, d);
    check(d == 32'h0A15_8080, "R5 command fields readback", 64'(d), 64'h0A15_8080);

    // Fast divider
    bus_write(4'h0, 32'h40);
    cur_h = 1;
    issue(1, 5'h05, 5'h02, 16'h1234, 1);
    issue(0, 5'h1E, 5'h11, 16'h5A00, 1);

    // R6: start while busy is ignored
    bus_write(4'h0, 32'h41);
    cur_h = 2;
    issue(0, 5'h07, 5'h09, 16'hC0DE, 0);
    repeat (30) @(negedge clk);
    bus_write(4'h4, cmd_word(2'b10, 5'h1C, 5'h1B));
    wait_ready();
    repeat (300) @(negedge clk);
    check(frames_seen == frames_issued, "R6 no extra frame from busy start",
          64'(frames_seen), 64'(frames_issued));
    bus_read(4'h4, d);
    check(d == 32'h0709_4080, "R6 fields kept after busy start", 64'(d), 64'h0709_4080);
    check(q.size() == 0, "R4 scoreboard drained", 64'(q.size()), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule